// File: doc/BRIEF.md
# PRBS-31 Link Bit Error Tester

This block turns a parallel link datapath into a bit error rate test set. When the transmit test enable is set, the outbound word stream stops carrying cells. It carries the raw pseudo-random sequence of x^31 + x^28 + 1 instead. While the enable is set, the cell assembler is told to pause and the transmit queue is never read. The block handles one word of `DW` bits per clock.

On the receive side, a checker takes its seed from the incoming bits. It then proves the seed on a run of clean bits and declares lock. After lock it predicts every bit from its own local register, so one flipped bit on the line counts as exactly one error. Errors seen while locked go into a 24-bit counter. Software reads the counter at fixed intervals to estimate the bit error rate, and each read clears it. The counter has no threshold and no interrupt. A burst of errors that is too dense makes the checker drop lock and seed again. The count is only meaningful while both the transmit and the receive enables are set, and the block reports that condition. No cell or frame structure exists in this mode, so losing frame delineation downstream is expected.

Top module: `prbs31_link_tester`

## Requirements
- R1: With `tx_prbs_en` high, each clock edge loads `tx_word` with the next `DW` bits of the sequence b[n] = b[n-31] XOR b[n-28]. The earliest bit goes in bit `DW-1`. The generator history is all ones after reset, and the first enabled edge produces the bits that follow that history.
- R2: While `tx_prbs_en` is high, `cell_word` has no effect on `tx_word`, `asm_pause` is 1 and `q_rd_en` is 0.
- R3: While `tx_prbs_en` is low, `tx_word` takes `cell_word` at each edge, `asm_pause` is 0, `q_rd_en` follows `cell_rd_req`, and the generator holds its place in the sequence.
- R4: After `rx_cnt_en` rises, the checker loads 31 received bits as its seed. It then needs 64 consecutive bits that match its prediction before `rx_locked` goes high. For `DW`=8 with a clean stream, that is after the 12th word and not after the 11th. A mismatch during the proving run restarts the seeding.
- R5: While locked, every mismatching bit of a received word adds one to `err_count` at the edge that takes in that word.
- R6: When `cnt_rd` is high at an edge, `err_count` is reloaded with the error count of the word taken in at that edge. That value is 0 for a clean word, so the read clears the counter.
- R7: More than 16 errors within any 64 consecutive locked bits drops `rx_locked`. Exactly 16 does not. The bit that crosses the limit is still counted. Seeding restarts with the next bit.
- R8: While `rx_cnt_en` is low, the checker is unlocked and idle, and `err_count` does not change unless `cnt_rd` is high.
- R9: `cnt_valid` is high exactly when both `tx_prbs_en` and `rx_cnt_en` are high.
- R10: After reset, `tx_word`, `err_count` and `rx_locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_prbs_en | input | 1 | Transmit test pattern enable |
| cell_word | input | DW | Cell data word from the assembler |
| cell_rd_req | input | 1 | Assembler request to read the transmit queue |
| tx_word | output | DW | Outbound link word |
| asm_pause | output | 1 | Pause to the cell assembler |
| q_rd_en | output | 1 | Transmit queue read enable |
| rx_cnt_en | input | 1 | Receive error count enable |
| rx_word | input | DW | Inbound link word |
| cnt_rd | input | 1 | Counter read strobe, clears the count |
| rx_locked | output | 1 | Checker locked to the sequence |
| err_count | output | CNT_W | Bit error count |
| cnt_valid | output | 1 | Count is meaningful |

## Verification
`tx_word`, `rx_locked` and `err_count` are registered. Each one changes at the first rising edge after its stimulus. `asm_pause`, `q_rd_en` and `cnt_valid` follow their inputs within the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, so exactly one register lies between stimulus and check. The lock boundary is checked at the 11th and 12th words after seeding starts. Errors are injected by XOR onto the looped-back word in the cycle before the edge that consumes it. An independent bit-serial model is compared against `tx_word` on every enabled cycle.

// File: rtl/prbs31_pkg.sv
// Package prbs31_pkg
// Shared constants and the checker phase type for the PRBS-31 link tester.
// Assumes the sequence b[n] = b[n-31] ^ b[n-28].
package prbs31_pkg;
    localparam int SR_LEN = 31;   // generator length (x^31 term)
    localparam int TAP    = 28;   // feedback tap (x^28 term)

    typedef enum logic [1:0] {
        PH_SEED   = 2'd0,
        PH_VERIFY = 2'd1,
        PH_LOCK   = 2'd2
    } chk_phase_e;
endpackage

// File: rtl/prbs31_gen.sv
// Module prbs31_gen
// Transmit side. It produces DW sequence bits per clock while enabled and
// passes cell words through otherwise. The earliest bit goes out in bit DW-1.
// Assumes a synchronous active-low reset and an all-ones initial history.
module prbs31_gen
    import prbs31_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] cell_word,
    output logic [DW-1:0] tx_word
);
    logic [SR_LEN-1:0] sr_q, sr_n;
    logic [DW-1:0]     pat_n;

    // Unroll DW serial steps of the recurrence to form the next word.
    always_comb begin
        logic nb;
        sr_n  = sr_q;
        pat_n = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            nb       = sr_n[SR_LEN-1] ^ sr_n[TAP-1];
            pat_n[i] = nb;
            sr_n     = {sr_n[SR_LEN-2:0], nb};
        end
    end

    // Advance the history and register the outbound word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '1;
            tx_word <= '0;
        end else if (en) begin
            sr_q    <= sr_n;
            tx_word <= pat_n;
        end else begin
            tx_word <= cell_word;
        end
    end

    // R1
    sr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sr_q));
endmodule

// File: rtl/prbs31_chk.sv
// Module prbs31_chk
// Receive side. It seeds from SR_LEN received bits and proves the seed on
// RUN_LEN clean bits. Once locked it predicts each bit locally and reports
// the mismatches per word. More than ERR_LIM errors in any WIN_LEN locked
// bits drops lock. Assumes the earliest bit is in bit DW-1.
module prbs31_chk
    import prbs31_pkg::*;
#(
    parameter int DW      = 8,
    parameter int RUN_LEN = 64,
    parameter int WIN_LEN = 64,
    parameter int ERR_LIM = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [DW-1:0]              rx_word,
    output logic                       locked,
    output logic [$clog2(DW+1)-1:0]    err_bits
);
    localparam int RMAX = (RUN_LEN > SR_LEN) ? RUN_LEN : SR_LEN;
    localparam int RW   = $clog2(RMAX + 1);
    localparam int WW   = $clog2(WIN_LEN + 1);
    localparam int EW   = $clog2(DW + 1);

    chk_phase_e        ph_q, ph_n;
    logic [SR_LEN-1:0] hist_q, hist_n;
    logic [RW-1:0]     run_q, run_n;
    logic [WIN_LEN-1:0] ewin_q, ewin_n;
    logic [WW-1:0]     wcnt_q, wcnt_n;
    logic [EW-1:0]     errs_n;

    // Walk the word bit by bit through seed, prove and locked counting.
    always_comb begin
        logic pred, bv, e;
        ph_n   = ph_q;
        hist_n = hist_q;
        run_n  = run_q;
        ewin_n = ewin_q;
        wcnt_n = wcnt_q;
        errs_n = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            pred = hist_n[SR_LEN-1] ^ hist_n[TAP-1];
            bv   = rx_word[i];
            e    = bv ^ pred;
            case (ph_n)
                PH_SEED: begin
                    hist_n = {hist_n[SR_LEN-2:0], bv};
                    if (run_n == RW'(SR_LEN - 1)) begin
                        ph_n  = PH_VERIFY;
                        run_n = '0;
                    end else begin
                        run_n = run_n + 1'b1;
                    end
                end
                PH_VERIFY: begin
                    if (e) begin
                        ph_n  = PH_SEED;
                        run_n = '0;
                    end else begin
                        hist_n = {hist_n[SR_LEN-2:0], pred};
                        if (run_n == RW'(RUN_LEN - 1)) begin
                            ph_n   = PH_LOCK;
                            run_n  = '0;
                            ewin_n = '0;
                            wcnt_n = '0;
                        end else begin
                            run_n = run_n + 1'b1;
                        end
                    end
                end
                PH_LOCK: begin
                    errs_n = errs_n + EW'(e);
                    hist_n = {hist_n[SR_LEN-2:0], pred};
                    wcnt_n = wcnt_n + WW'(e) - WW'(ewin_n[WIN_LEN-1]);
                    ewin_n = {ewin_n[WIN_LEN-2:0], e};
                    if (wcnt_n > WW'(ERR_LIM)) begin
                        ph_n  = PH_SEED;
                        run_n = '0;
                    end
                end
                default: begin
                    ph_n  = PH_SEED;
                    run_n = '0;
                end
            endcase
        end
    end

    // Hold checker state. Reset or a disabled count returns it to seeding.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ph_q   <= PH_SEED;
            hist_q <= '0;
            run_q  <= '0;
            ewin_q <= '0;
            wcnt_q <= '0;
        end else begin
            ph_q   <= ph_n;
            hist_q <= hist_n;
            run_q  <= run_n;
            ewin_q <= ewin_n;
            wcnt_q <= wcnt_n;
        end
    end

    assign locked   = (ph_q == PH_LOCK);
    assign err_bits = en ? errs_n : '0;

    // R8
    idle_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !locked);
    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ph_q) == PH_VERIFY);
    // R7
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> wcnt_q <= WW'(ERR_LIM));
    // R5
    err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits != '0) |-> en);
endmodule

// File: rtl/prbs31_err_counter.sv
// Module prbs31_err_counter
// Saturating error counter that clears on read. On a read edge it is
// reloaded with that edge's increment, so no error is lost across a read.
module prbs31_err_counter #(
    parameter int CNT_W = 24,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W:0] sum;

    // Form the widened sum used for saturation.
    always_comb sum = {1'b0, count} + (CNT_W + 1)'(inc);

    // Accumulate, reload on read, stop at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= CNT_W'(inc);
        else if (sum[CNT_W])
            count <= '1;
        else
            count <= sum[CNT_W-1:0];
    end

    // R5
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count >= $past(count));
    // R6
    clr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count <= CNT_W'((1 << INC_W) - 1));
endmodule

// File: rtl/prbs31_link_tester.sv
// Module prbs31_link_tester
// Top level. It joins the transmit pattern generator, the receive checker
// and the read-cleared error counter. It also gates the cell assembler and
// the transmit queue while the test pattern is on.
module prbs31_link_tester #(
    parameter int DW      = 8,
    parameter int CNT_W   = 24,
    parameter int RUN_LEN = 64,
    parameter int WIN_LEN = 64,
    parameter int ERR_LIM = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_prbs_en,
    input  logic [DW-1:0]    cell_word,
    input  logic             cell_rd_req,
    output logic [DW-1:0]    tx_word,
    output logic             asm_pause,
    output logic             q_rd_en,
    input  logic             rx_cnt_en,
    input  logic [DW-1:0]    rx_word,
    input  logic             cnt_rd,
    output logic             rx_locked,
    output logic [CNT_W-1:0] err_count,
    output logic             cnt_valid
);
    localparam int EW = $clog2(DW + 1);

    logic [EW-1:0] err_bits;

    prbs31_gen #(.DW(DW)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_prbs_en),
        .cell_word (cell_word),
        .tx_word   (tx_word)
    );

    prbs31_chk #(
        .DW(DW), .RUN_LEN(RUN_LEN), .WIN_LEN(WIN_LEN), .ERR_LIM(ERR_LIM)
    ) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_cnt_en),
        .rx_word  (rx_word),
        .locked   (rx_locked),
        .err_bits (err_bits)
    );

    prbs31_err_counter #(.CNT_W(CNT_W), .INC_W(EW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_rd),
        .inc   (err_bits),
        .count (err_count)
    );

    // Cell path gating and count validity.
    always_comb begin
        asm_pause = tx_prbs_en;
        q_rd_en   = cell_rd_req & ~tx_prbs_en;
        cnt_valid = tx_prbs_en & rx_cnt_en;
    end
endmodule

// File: tb/tb_prbs31_link_tester.sv
module tb_prbs31_link_tester;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_prbs_en = 1'b0;
    logic [7:0]  cell_word = '0;
    logic        cell_rd_req = 1'b0;
    logic [7:0]  tx_word;
    logic        asm_pause, q_rd_en;
    logic        rx_cnt_en = 1'b0;
    logic [7:0]  rx_word;
    logic [7:0]  inj_mask = '0;
    logic        cnt_rd = 1'b0;
    logic        rx_locked;
    logic [23:0] err_count;
    logic        cnt_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // loopback with error injection
    assign rx_word = tx_word ^ inj_mask;

    prbs31_link_tester dut (
        .clk(clk), .rst_n(rst_n), .tx_prbs_en(tx_prbs_en),
        .cell_word(cell_word), .cell_rd_req(cell_rd_req),
        .tx_word(tx_word), .asm_pause(asm_pause), .q_rd_en(q_rd_en),
        .rx_cnt_en(rx_cnt_en), .rx_word(rx_word), .cnt_rd(cnt_rd),
        .rx_locked(rx_locked), .err_count(err_count), .cnt_valid(cnt_valid)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial reference for R1: b[n] = b[n-31] ^ b[n-28], earliest bit to MSB.
    logic [30:0] mh;
    logic [7:0]  mword;
    logic        mvalid;
    always @(posedge clk) begin
        if (!rst_n) begin
            mh     <= '1;
            mvalid <= 1'b0;
        end else begin
            mvalid <= tx_prbs_en;
            if (tx_prbs_en) begin : step
                logic [30:0] h;
                logic [7:0]  w;
                logic        b;
                h = mh;
                for (int k = 0; k < 8; k++) begin
                    b = h[30] ^ h[27];
                    w[7-k] = b;
                    h = {h[29:0], b};
                end
                mh    <= h;
                mword <= w;
            end
        end
    end

    // R1: compare every enabled output word with the model
    always @(negedge clk) begin
        if (rst_n && mvalid && !done)
            chk("R1 gen word", {24'd0, tx_word}, {24'd0, mword});
    end

    typedef struct packed {
        logic [7:0]  mask;
        logic        rd;
        logic [23:0] cnt;
        logic        lk;
    } vec_t;

    // R5 / R6 stimulus table: injected mask, read strobe, expected count, lock
    localparam vec_t TBL [12] = '{
        '{8'h00, 1'b0, 24'd0,  1'b1},
        '{8'h01, 1'b0, 24'd1,  1'b1},
        '{8'h80, 1'b0, 24'd2,  1'b1},
        '{8'h00, 1'b0, 24'd2,  1'b1},
        '{8'h11, 1'b0, 24'd4,  1'b1},
        '{8'h00, 1'b1, 24'd0,  1'b1},
        '{8'h03, 1'b1, 24'd2,  1'b1},
        '{8'h00, 1'b0, 24'd2,  1'b1},
        '{8'hFF, 1'b0, 24'd10, 1'b1},
        '{8'h00, 1'b0, 24'd10, 1'b1},
        '{8'h00, 1'b1, 24'd0,  1'b1},
        '{8'h00, 1'b0, 24'd0,  1'b1}
    };

    task automatic word(input logic [7:0] m, input logic rd);
        inj_mask = m;
        cnt_rd   = rd;
        @(negedge clk);
        inj_mask = '0;
        cnt_rd   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 tx_word", {24'd0, tx_word}, 0);
        chk("R10 err_count", {8'd0, err_count}, 0);
        chk("R10 rx_locked", {31'd0, rx_locked}, 0);
        rst_n = 1'b1;
        cell_rd_req = 1'b1;
        @(negedge clk);
        chk("R3 q_rd_en follows req", {31'd0, q_rd_en}, 1);

        // R2 pattern on, cells ignored, queue gated
        tx_prbs_en = 1'b1;
        cell_word  = 8'h5A;
        #1;
        chk("R2 asm_pause", {31'd0, asm_pause}, 1);
        chk("R2 q_rd_en", {31'd0, q_rd_en}, 0);
        chk("R9 valid tx only", {31'd0, cnt_valid}, 0);
        repeat (2) @(negedge clk);

        // R4 lock boundary
        rx_cnt_en = 1'b1;
        #1;
        chk("R9 valid both", {31'd0, cnt_valid}, 1);
        repeat (11) @(negedge clk);
        chk("R4 not locked after 11 words", {31'd0, rx_locked}, 0);
        @(negedge clk);
        chk("R4 locked after 12 words", {31'd0, rx_locked}, 1);
        chk("R5 clean count", {8'd0, err_count}, 0);

        // R5 / R6 table walk
        for (int i = 0; i < 12; i++) begin
            word(TBL[i].mask, TBL[i].rd);
            chk($sformatf("R5 R6 table %0d count", i), {8'd0, err_count}, {8'd0, TBL[i].cnt});
            chk($sformatf("R5 table %0d lock", i), {31'd0, rx_locked}, {31'd0, TBL[i].lk});
        end

        // R7 exactly 16 in a window keeps lock
        repeat (8) word(8'h00, 1'b0);
        word(8'hFF, 1'b0);
        word(8'hFF, 1'b0);
        chk("R7 16 errors count", {8'd0, err_count}, 16);
        chk("R7 16 errors keep lock", {31'd0, rx_locked}, 1);
        // R7 seventeen drops lock, last one counted
        repeat (8) word(8'h00, 1'b0);
        word(8'hFF, 1'b0);
        word(8'hFF, 1'b0);
        word(8'h01, 1'b0);
        chk("R7 17th error counted", {8'd0, err_count}, 33);
        chk("R7 lock dropped", {31'd0, rx_locked}, 0);
        repeat (11) word(8'h00, 1'b0);
        chk("R4 reseed not locked at 11", {31'd0, rx_locked}, 0);
        word(8'h00, 1'b0);
        chk("R4 relocked at 12", {31'd0, rx_locked}, 1);
        chk("R5 count held while reseeding", {8'd0, err_count}, 33);

        // R4 mismatch during proving restarts seeding
        rx_cnt_en = 1'b0;
        @(negedge clk);
        rx_cnt_en = 1'b1;
        repeat (5) word(8'h00, 1'b0);
        word(8'h10, 1'b0);
        repeat (11) word(8'h00, 1'b0);
        chk("R4 proving error delays lock", {31'd0, rx_locked}, 0);
        repeat (2) word(8'h00, 1'b0);
        chk("R4 locked after restart", {31'd0, rx_locked}, 1);

        // R8 disabled receive ignores errors
        rx_cnt_en = 1'b0;
        #1;
        chk("R9 valid rx off", {31'd0, cnt_valid}, 0);
        word(8'hFF, 1'b0);
        word(8'hFF, 1'b0);
        chk("R8 unlocked", {31'd0, rx_locked}, 0);
        chk("R8 count held", {8'd0, err_count}, 33);
        word(8'h00, 1'b1);
        chk("R6 read clears while idle", {8'd0, err_count}, 0);

        // R3 pattern off: cells pass, generator holds
        tx_prbs_en = 1'b0;
        cell_word  = 8'hA5;
        #1;
        chk("R3 asm_pause low", {31'd0, asm_pause}, 0);
        chk("R3 q_rd_en passes", {31'd0, q_rd_en}, 1);
        chk("R9 valid none", {31'd0, cnt_valid}, 0);
        @(negedge clk);
        chk("R3 cell word out", {24'd0, tx_word}, 32'hA5);
        cell_word = 8'h3C;
        @(negedge clk);
        chk("R3 cell word follows", {24'd0, tx_word}, 32'h3C);
        // re-enable: model comparator checks continuity (R1/R3)
        tx_prbs_en = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 tx_word not cell", {31'd0, tx_word == 8'h3C && mword != 8'h3C}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule